// File: doc/BRIEF.md
# Inter-Processor and Timer Interrupt Controller

This block holds, for each of up to four processors, one inter-processor interrupt (IPI) pending bit and one interval-timer pending bit. Each bit drives a level interrupt output. Software posts and retires IPIs and retires timer interrupts by writing per-CPU bit fields of a 64-bit control word. It can also write a plain CPU bitmask to one of three single-purpose registers, one for each action. A one-cycle tick pulse from an external interval timer posts the timer interrupt to every active processor.

Only processors whose index is below the parameter `ACTIVE_CPUS` take part. Mask bits for any other processor are dropped. Requests that change nothing are flagged on warning outputs and leave the state as it was: a post to a processor that already has an IPI pending, or a clear of an IPI that is not pending. A write that selects no active processor at all is flagged as an error.

Top module: `ipi_timer_ctrl`

## Requirements
- R1: After reset, every pending bit is 0, `ipi_irq` and `timer_irq` are 0, and the three flag outputs are 0.
- R2: A write to word address 0 (control word) acts per CPU from three 4-bit fields: bits 15:12 post an IPI, bits 11:8 clear an IPI, and bits 7:4 clear a timer interrupt. Bit n of a field addresses CPU n. The outputs show the new state right after the clock edge that takes the write.
- R3: An IPI post to a CPU whose IPI is already pending leaves that bit unchanged. It raises `dup_post_warn` for the one cycle after the write edge.
- R4: An IPI clear to a CPU with no pending IPI leaves the state unchanged. It raises `idle_clear_warn` for the one cycle after the write edge.
- R5: `empty_err` pulses for one cycle after either of two writes: a write to a single-purpose register whose mask selects no active CPU, or a control-word write whose three fields together select no active CPU. Neither write changes any state.
- R6: A `tick` pulse sets the timer pending bit of every active CPU. The bit is visible on `timer_irq` right after that edge.
- R7: A timer clear resets only the CPUs whose bits are set both in the clear mask and in the timer pending state. Clearing a timer bit that is not pending raises no flag.
- R8: Word address 1 clears IPIs, address 2 clears timer interrupts and address 3 posts IPIs. Each takes a CPU mask in `wr_data[3:0]`, and each reads as 0.
- R9: CPUs with index at or above `ACTIVE_CPUS` (default 3) never change state, and their `ipi_irq` and `timer_irq` bits stay 0.
- R10: Reading word address 0 returns the IPI pending bits in 11:8 and the timer pending bits in 7:4. All other bits read 0.
- R11: When a clear and a post reach the same CPU in the same cycle, the clear is applied first and the post then sets the bit. This holds for an IPI clear and post in one control-word write, and for a timer clear together with `tick`. Neither case raises a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Word address of the write |
| wr_data | input | 64 | Write data |
| rd_addr | input | 2 | Word address of the read |
| rd_data | output | 64 | Read data (combinational) |
| tick | input | 1 | One-cycle interval-timer pulse |
| ipi_irq | output | 4 | Per-CPU IPI level outputs |
| timer_irq | output | 4 | Per-CPU timer level outputs |
| dup_post_warn | output | 1 | Post to an already-pending IPI |
| idle_clear_warn | output | 1 | Clear of a non-pending IPI |
| empty_err | output | 1 | Write that selected no active CPU |

## Verification
Pending bits and both interrupt outputs change on the clock edge that takes a write or a tick. The three flags are registered pulses that are valid only in the cycle after that edge. Read data is combinational from the current state. The bench drives every stimulus on a falling edge and holds it through one rising edge. It then samples outputs and flags at the next falling edge, which is the only cycle in which a flag pulse can be seen.

// File: rtl/ipi_timer_ctrl.sv
module ipi_timer_ctrl #(
  parameter int NCPU        = 4,
  parameter int ACTIVE_CPUS = 3,
  parameter int DW          = 64,
  parameter int AW          = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          tick,
  output logic [NCPU-1:0] ipi_irq,
  output logic [NCPU-1:0] timer_irq,
  output logic          dup_post_warn,
  output logic          idle_clear_warn,
  output logic          empty_err
);
  localparam int TCLR_LSB = 4;
  localparam int ICLR_LSB = TCLR_LSB + NCPU;
  localparam int IREQ_LSB = ICLR_LSB + NCPU;
  localparam int TOP_USED = IREQ_LSB + NCPU;
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_ICLR = AW'(1);
  localparam logic [AW-1:0] A_TCLR = AW'(2);
  localparam logic [AW-1:0] A_IREQ = AW'(3);
  localparam logic [NCPU-1:0] ACT = NCPU'((64'd1 << ACTIVE_CPUS) - 64'd1);

  logic [NCPU-1:0] ipi_q, tmr_q;
  logic [NCPU-1:0] req, iclr, tclr, ipi_kept;
  logic            is_ctrl, is_mask, dup_d, idle_d, empty_d;
  logic            unused_hi;

  assign is_ctrl = wr_en && (wr_addr == A_CTRL);
  assign is_mask = wr_en && (wr_addr != A_CTRL);

  assign req  = ACT & (is_ctrl ? wr_data[IREQ_LSB +: NCPU] :
                       (wr_en && wr_addr == A_IREQ) ? wr_data[NCPU-1:0] : '0);
  assign iclr = ACT & (is_ctrl ? wr_data[ICLR_LSB +: NCPU] :
                       (wr_en && wr_addr == A_ICLR) ? wr_data[NCPU-1:0] : '0);
  assign tclr = ACT & (is_ctrl ? wr_data[TCLR_LSB +: NCPU] :
                       (wr_en && wr_addr == A_TCLR) ? wr_data[NCPU-1:0] : '0);

  assign ipi_kept = ipi_q & ~iclr;
  assign dup_d    = |(req & ipi_kept);
  assign idle_d   = |(iclr & ~ipi_q);
  assign empty_d  = (is_ctrl || is_mask) && ((req | iclr | tclr) == '0);
  assign unused_hi = &{1'b0, wr_data[DW-1:TOP_USED]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ipi_q           <= '0;
      tmr_q           <= '0;
      dup_post_warn   <= 1'b0;
      idle_clear_warn <= 1'b0;
      empty_err       <= 1'b0;
    end else begin
      ipi_q           <= ipi_kept | req;
      tmr_q           <= (tmr_q & ~tclr) | (tick ? ACT : '0);
      dup_post_warn   <= dup_d;
      idle_clear_warn <= idle_d;
      empty_err       <= empty_d;
    end
  end

  assign ipi_irq   = ipi_q;
  assign timer_irq = tmr_q;

  always_comb begin
    rd_data = '0;
    if (rd_addr == A_CTRL) begin
      rd_data[ICLR_LSB +: NCPU] = ipi_q;
      rd_data[TCLR_LSB +: NCPU] = tmr_q;
    end
  end

  // R6
  tick_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> ((timer_irq & ACT) == ACT));

  // R2
  ipi_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ipi_irq & ~$past(ipi_irq)) != '0) |->
      $past(wr_en && (wr_addr == A_CTRL || wr_addr == A_IREQ)));

  // R4
  ipi_fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(ipi_irq) & ~ipi_irq) != '0) |->
      $past(wr_en && (wr_addr == A_CTRL || wr_addr == A_ICLR)));

  // R7
  tmr_fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(timer_irq) & ~timer_irq) != '0) |->
      $past(wr_en && (wr_addr == A_CTRL || wr_addr == A_TCLR)));

  // R9
  inactive_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ipi_irq | timer_irq) & ~ACT) == '0);

  // R5
  empty_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty_err |-> ($stable(ipi_irq) && !dup_post_warn && !idle_clear_warn));
endmodule

// File: tb/sim_ipi_timer_ctrl.sv
module sim_ipi_timer_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [63:0] rd_data;
  logic        tick = 1'b0;
  logic [3:0]  ipi_irq, timer_irq;
  logic        dup_post_warn, idle_clear_warn, empty_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  ipi_timer_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .tick(tick),
    .ipi_irq(ipi_irq), .timer_irq(timer_irq), .dup_post_warn(dup_post_warn),
    .idle_clear_warn(idle_clear_warn), .empty_err(empty_err)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic flags(input string req, input logic d, input logic i, input logic e);
    chk(req, {61'd0, dup_post_warn, idle_clear_warn, empty_err}, {61'd0, d, i, e});
  endtask

  task automatic wr(input logic [1:0] a, input logic [63:0] d, input logic t);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; tick = t;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; tick = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset();
    rd_addr = 2'd0;
    #1;
    chk("R1 ipi", {60'd0, ipi_irq}, 64'h0);
    chk("R1 timer", {60'd0, timer_irq}, 64'h0);
    flags("R1 flags", 0, 0, 0);
    chk("R1 read", rd_data, 64'h0);
  endtask

  task automatic t_ctrl_ipi();
    wr(2'd0, 64'h5000, 1'b0);
    chk("R2 post 0,2", {60'd0, ipi_irq}, 64'h5);
    flags("R2 flags", 0, 0, 0);
    wr(2'd0, 64'h1000, 1'b0);
    chk("R3 dup state", {60'd0, ipi_irq}, 64'h5);
    flags("R3 dup flag", 1, 0, 0);
    @(negedge clk);
    flags("R3 one cycle", 0, 0, 0);
    wr(2'd0, 64'h0600, 1'b0);
    chk("R4 clear", {60'd0, ipi_irq}, 64'h1);
    flags("R4 idle flag", 0, 1, 0);
  endtask

  task automatic t_inactive();
    wr(2'd0, 64'h8000, 1'b0);
    chk("R9 cpu3 ignored", {60'd0, ipi_irq}, 64'h1);
    flags("R5 no active cpu", 0, 0, 1);
    wr(2'd0, 64'h0, 1'b0);
    chk("R5 zero ctrl state", {60'd0, ipi_irq}, 64'h1);
    flags("R5 zero ctrl", 0, 0, 1);
  endtask

  task automatic t_timer();
    pulse_tick();
    chk("R6 tick", {60'd0, timer_irq}, 64'h7);
    pulse_tick();
    chk("R6 tick again", {60'd0, timer_irq}, 64'h7);
    wr(2'd0, 64'h0030, 1'b0);
    chk("R7 clear 0,1", {60'd0, timer_irq}, 64'h4);
    wr(2'd0, 64'h0030, 1'b0);
    chk("R7 clear idle", {60'd0, timer_irq}, 64'h4);
    flags("R7 no flag", 0, 0, 0);
  endtask

  task automatic t_readback();
    rd_addr = 2'd0;
    #1;
    chk("R10 ctrl read", rd_data, 64'h140);
    for (int a = 1; a < 4; a++) begin
      rd_addr = 2'(a);
      #1;
      chk("R8 mask reg reads 0", rd_data, 64'h0);
    end
    rd_addr = 2'd0;
  endtask

  task automatic t_mask_regs();
    wr(2'd3, 64'h6, 1'b0);
    chk("R8 mask post", {60'd0, ipi_irq}, 64'h7);
    wr(2'd1, 64'h1, 1'b0);
    chk("R8 mask ipi clear", {60'd0, ipi_irq}, 64'h6);
    wr(2'd2, 64'h4, 1'b0);
    chk("R8 mask timer clear", {60'd0, timer_irq}, 64'h0);
    wr(2'd1, 64'h8, 1'b0);
    chk("R5 mask empty state", {60'd0, ipi_irq}, 64'h6);
    flags("R5 mask empty", 0, 0, 1);
    wr(2'd3, 64'h2, 1'b0);
    flags("R3 mask dup", 1, 0, 0);
  endtask

  task automatic t_same_cycle();
    wr(2'd0, 64'h2200, 1'b0);
    chk("R11 ipi clear+post", {60'd0, ipi_irq}, 64'h6);
    flags("R11 no flag", 0, 0, 0);
    pulse_tick();
    wr(2'd2, 64'h1, 1'b1);
    chk("R11 timer clear+tick", {60'd0, timer_irq}, 64'h7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_ctrl_ipi();
    t_inactive();
    t_timer();
    t_readback();
    t_mask_regs();
    t_same_cycle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule